// File: doc/BRIEF.md
# Keyboard and Mouse Output Buffer Arbiter

This block merges two byte streams, one from a keyboard channel and one from an auxiliary pointing-device channel, into the single data register that the host reads. Each channel has its own FIFO. The producer side of each FIFO is a valid/ready stream. A beat is accepted on any rising clock edge where both valid and ready are high. Ready falls while the FIFO is full. A beat offered while ready is low is dropped and sets that channel's sticky overflow flag. Producers that respect ready never lose data.

The keyboard channel has fixed priority. A host read strobe takes the next byte from the keyboard FIFO whenever that FIFO holds data. It takes the auxiliary FIFO only when the keyboard FIFO is empty. The block derives the output-full status, the auxiliary-full status, a mirrored pair of output-port bits and two level interrupts from which FIFOs hold data and from three mode inputs. The auxiliary-full flag and the auxiliary interrupt are raised only when the auxiliary channel is the sole source of data.

Top module: `kbc_obuf_arbiter`

## Requirements
- R1: After reset, host_data is 0x00, every status, port, interrupt and overflow output is low, and both push ready outputs are high.
- R2: stat_obf and port_obf are high exactly when at least one of the two FIFOs holds a byte.
- R3: stat_aux_obf and port_aux_obf are high exactly when the auxiliary FIFO holds data and the keyboard FIFO is empty.
- R4: irq_aux is high exactly when the auxiliary channel is the sole source of data and mode_aux_irq_en is 1.
- R5: irq_kbd is high exactly when the keyboard FIFO holds data, mode_kbd_irq_en is 1 and mode_kbd_off is 0.
- R6: On a clock edge with host_rd high, host_data takes the head byte of the auxiliary FIFO if that FIFO is the sole non-empty one, and otherwise the head byte of the keyboard FIFO. That byte is removed from its FIFO. The new value is visible after that edge, and each channel's bytes come out in push order.
- R7: A host_rd strobe while both FIFOs are empty leaves host_data and every flag unchanged.
- R8: Each FIFO holds DEPTH (default 16) bytes. Its push ready output is low exactly when the FIFO is full. A beat offered while full is discarded and sets that channel's overflow output, which stays high until reset.
- R9: The flag and interrupt outputs follow the mode inputs combinationally, with no clock edge needed.
- R10: A push and a read of the same channel on the same edge both take effect. The read returns the previous head, and the pushed byte is queued behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_push_valid | input | 1 | Keyboard byte offered |
| kbd_push_data | input | 8 | Keyboard byte |
| kbd_push_ready | output | 1 | Keyboard FIFO can accept a byte |
| aux_push_valid | input | 1 | Auxiliary byte offered |
| aux_push_data | input | 8 | Auxiliary byte |
| aux_push_ready | output | 1 | Auxiliary FIFO can accept a byte |
| mode_kbd_irq_en | input | 1 | Allow keyboard interrupt |
| mode_aux_irq_en | input | 1 | Allow auxiliary interrupt |
| mode_kbd_off | input | 1 | Keyboard interface disabled (masks keyboard interrupt) |
| host_rd | input | 1 | Host data-read strobe, one byte per high cycle |
| host_data | output | 8 | Last byte delivered to the host |
| stat_obf | output | 1 | Output buffer full status |
| stat_aux_obf | output | 1 | Output buffer holds auxiliary data |
| port_obf | output | 1 | Output-port copy of stat_obf |
| port_aux_obf | output | 1 | Output-port copy of stat_aux_obf |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| kbd_ovf | output | 1 | Sticky keyboard overflow |
| aux_ovf | output | 1 | Sticky auxiliary overflow |

## Verification
The priority rule is exercised with keyboard-only data, auxiliary-only data, and both channels loaded at once. The last case distinguishes the sole-source auxiliary flag from a plain "auxiliary non-empty" flag, because the auxiliary flag must stay low until the last keyboard byte is read. Mode sweeps with data held still separate the interrupt gating from the status flags, and disabling the keyboard must drop only irq_kbd. Overfilling one FIFO, reading with both FIFOs empty, and pushing and reading on the same edge cover the boundary behaviour of the storage and the read register.

// File: rtl/kbc_obuf_pkg.sv
package kbc_obuf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_CH   = 2;
  localparam int unsigned CH_KBD = 0;
  localparam int unsigned CH_AUX = 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_KBD  = 2'd1,
    SRC_AUX  = 2'd2
  } src_e;
endpackage

// File: rtl/kbc_byte_fifo.sv
module kbc_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  assign full       = (count == FULL);
  assign empty      = (count == '0);
  assign push_ready = !full;
  assign do_push    = push_valid && !full;
  assign do_pop     = pop && !empty;
  assign head       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_valid && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/kbc_src_select.sv
module kbc_src_select
  import kbc_obuf_pkg::*;
(
  input  logic kbd_has,
  input  logic aux_has,
  input  logic kbd_irq_en,
  input  logic aux_irq_en,
  input  logic kbd_off,
  output src_e src,
  output logic any_full,
  output logic aux_only,
  output logic irq_kbd,
  output logic irq_aux
);
  always_comb begin
    src      = SRC_NONE;
    any_full = 1'b0;
    aux_only = 1'b0;
    irq_kbd  = 1'b0;
    irq_aux  = 1'b0;
    if (kbd_has) begin
      src      = SRC_KBD;
      any_full = 1'b1;
      irq_kbd  = kbd_irq_en && !kbd_off;
    end else if (aux_has) begin
      src      = SRC_AUX;
      any_full = 1'b1;
      aux_only = 1'b1;
      irq_aux  = aux_irq_en;
    end
  end
endmodule

// File: rtl/kbc_obuf_arbiter.sv
module kbc_obuf_arbiter
  import kbc_obuf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_push_valid,
  input  logic [BYTE_W-1:0] kbd_push_data,
  output logic              kbd_push_ready,
  input  logic              aux_push_valid,
  input  logic [BYTE_W-1:0] aux_push_data,
  output logic              aux_push_ready,
  input  logic              mode_kbd_irq_en,
  input  logic              mode_aux_irq_en,
  input  logic              mode_kbd_off,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_data,
  output logic              stat_obf,
  output logic              stat_aux_obf,
  output logic              port_obf,
  output logic              port_aux_obf,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic              kbd_ovf,
  output logic              aux_ovf
);
  logic [N_CH-1:0]   ch_valid, ch_ready, ch_pop, ch_empty, ch_ovf;
  logic [BYTE_W-1:0] ch_data [N_CH];
  logic [BYTE_W-1:0] ch_head [N_CH];
  src_e              src;
  logic              any_full, aux_only;
  logic [BYTE_W-1:0] data_q;

  assign ch_valid[CH_KBD] = kbd_push_valid;
  assign ch_valid[CH_AUX] = aux_push_valid;
  assign ch_data[CH_KBD]  = kbd_push_data;
  assign ch_data[CH_AUX]  = aux_push_data;
  assign ch_pop[CH_KBD]   = host_rd && (src == SRC_KBD);
  assign ch_pop[CH_AUX]   = host_rd && (src == SRC_AUX);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    kbc_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (ch_valid[c]),
      .push_data  (ch_data[c]),
      .push_ready (ch_ready[c]),
      .pop        (ch_pop[c]),
      .head       (ch_head[c]),
      .empty      (ch_empty[c]),
      .overflow   (ch_ovf[c])
    );
  end

  kbc_src_select u_sel (
    .kbd_has    (!ch_empty[CH_KBD]),
    .aux_has    (!ch_empty[CH_AUX]),
    .kbd_irq_en (mode_kbd_irq_en),
    .aux_irq_en (mode_aux_irq_en),
    .kbd_off    (mode_kbd_off),
    .src        (src),
    .any_full   (any_full),
    .aux_only   (aux_only),
    .irq_kbd    (irq_kbd),
    .irq_aux    (irq_aux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (host_rd) begin
      case (src)
        SRC_KBD: data_q <= ch_head[CH_KBD];
        SRC_AUX: data_q <= ch_head[CH_AUX];
        default: data_q <= data_q;
      endcase
    end
  end

  assign host_data      = data_q;
  assign kbd_push_ready = ch_ready[CH_KBD];
  assign aux_push_ready = ch_ready[CH_AUX];
  assign kbd_ovf        = ch_ovf[CH_KBD];
  assign aux_ovf        = ch_ovf[CH_AUX];
  assign stat_obf       = any_full;
  assign stat_aux_obf   = aux_only;
  assign port_obf       = any_full;
  assign port_aux_obf   = aux_only;
endmodule

// File: rtl/kbc_obuf_arbiter_chk.sv
module kbc_obuf_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kbd_push_valid,
  input logic       kbd_push_ready,
  input logic       aux_push_valid,
  input logic       aux_push_ready,
  input logic       mode_kbd_irq_en,
  input logic       mode_aux_irq_en,
  input logic       mode_kbd_off,
  input logic       host_rd,
  input logic [7:0] host_data,
  input logic       stat_obf,
  input logic       stat_aux_obf,
  input logic       irq_kbd,
  input logic       irq_aux,
  input logic       kbd_ovf,
  input logic       aux_ovf
);
  // R3
  aux_flag_implies_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_aux_obf |-> stat_obf);
  // R4
  aux_irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> (stat_aux_obf && mode_aux_irq_en));
  // R5
  kbd_irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd |-> (stat_obf && !stat_aux_obf && mode_kbd_irq_en && !mode_kbd_off));
  // R7
  empty_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !stat_obf) |=> $stable(host_data));
  // R8
  kbd_drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_push_valid && !kbd_push_ready) |=> kbd_ovf);
  // R8
  aux_drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_push_valid && !aux_push_ready) |=> aux_ovf);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_ovf || aux_ovf) |=> ((kbd_ovf || !$past(kbd_ovf)) && (aux_ovf || !$past(aux_ovf))));
endmodule

bind kbc_obuf_arbiter kbc_obuf_arbiter_chk u_chk (.*);

// File: tb/kbc_obuf_arbiter_tb_top.sv
module kbc_obuf_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_push_valid = 1'b0, aux_push_valid = 1'b0;
  logic [7:0] kbd_push_data = '0, aux_push_data = '0;
  logic       kbd_push_ready, aux_push_ready;
  logic       mode_kbd_irq_en = 1'b1, mode_aux_irq_en = 1'b1, mode_kbd_off = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_data;
  logic       stat_obf, stat_aux_obf, port_obf, port_aux_obf;
  logic       irq_kbd, irq_aux, kbd_ovf, aux_ovf;

  always #10 clk = ~clk;

  kbc_obuf_arbiter dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  logic [7:0] kq[$], aq[$], exp_q[$], tag_q[$];
  logic [7:0] last_rd = 8'h00;
  bit m_kovf = 0, m_aovf = 0, mon_arm = 0;
  string mon_req = "";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data one half-cycle after capture
  always @(negedge clk) begin
    if (mon_arm) begin
      chk(mon_req, {24'd0, host_data}, {24'd0, exp_q.pop_front()});
      mon_arm = 0;
    end
  end

  task automatic check_flags(input string req);
    bit any, ao;
    @(negedge clk);
    any = (kq.size() != 0) || (aq.size() != 0);
    ao  = (kq.size() == 0) && (aq.size() != 0);
    chk({req, " R2 obf"}, {30'd0, stat_obf, port_obf}, {30'd0, any, any});
    chk({req, " R3 aux_obf"}, {30'd0, stat_aux_obf, port_aux_obf}, {30'd0, ao, ao});
    chk({req, " R4 irq_aux"}, {31'd0, irq_aux}, {31'd0, ao && mode_aux_irq_en});
    chk({req, " R5 irq_kbd"}, {31'd0, irq_kbd},
        {31'd0, (kq.size() != 0) && mode_kbd_irq_en && !mode_kbd_off});
    chk({req, " R8 ready/ovf"}, {28'd0, kbd_push_ready, aux_push_ready, kbd_ovf, aux_ovf},
        {28'd0, kq.size() < 16, aq.size() < 16, m_kovf, m_aovf});
  endtask

  function automatic logic [7:0] model_read();
    logic [7:0] e;
    if (kq.size() != 0) e = kq.pop_front();
    else if (aq.size() != 0) e = aq.pop_front();
    else e = last_rd;
    last_rd = e;
    return e;
  endfunction

  task automatic push(input bit aux, input logic [7:0] b);
    @(posedge clk); #2;
    if (aux) begin
      aux_push_valid = 1; aux_push_data = b;
      if (aq.size() < 16) aq.push_back(b); else m_aovf = 1;
    end else begin
      kbd_push_valid = 1; kbd_push_data = b;
      if (kq.size() < 16) kq.push_back(b); else m_kovf = 1;
    end
    @(posedge clk); #2;
    kbd_push_valid = 0; aux_push_valid = 0;
  endtask

  task automatic host_read(input string req, input bit with_kpush, input logic [7:0] b);
    @(posedge clk); #2;
    host_rd = 1;
    exp_q.push_back(model_read());
    if (with_kpush) begin
      kbd_push_valid = 1; kbd_push_data = b; kq.push_back(b);
    end
    @(posedge clk); #2;
    host_rd = 0; kbd_push_valid = 0;
    mon_req = req; mon_arm = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset data", {24'd0, host_data}, 32'h00);
    chk("R1 reset flags", {24'd0, stat_obf, stat_aux_obf, port_obf, port_aux_obf,
        irq_kbd, irq_aux, kbd_ovf, aux_ovf}, 32'h0);
    chk("R1 reset ready", {30'd0, kbd_push_ready, aux_push_ready}, 32'h3);

    // keyboard only
    push(0, 8'h1c); push(0, 8'h32); push(0, 8'h21);
    check_flags("kbd only");
    // both channels loaded: aux flag must stay low (R3)
    push(1, 8'h08); push(1, 8'hf1);
    check_flags("both loaded");
    host_read("R6 kbd first", 0, 0);
    host_read("R6 kbd order", 0, 0);
    check_flags("one kbd left");
    host_read("R6 kbd last", 0, 0);
    check_flags("aux sole");
    // R9: mode change without data change
    mode_aux_irq_en = 0;
    #1 chk("R9 irq_aux follows mode", {31'd0, irq_aux}, 32'd0);
    check_flags("aux irq off");
    mode_aux_irq_en = 1;
    host_read("R6 aux sole read", 0, 0);
    host_read("R6 aux drained", 0, 0);
    check_flags("drained");
    // R7 read while empty
    host_read("R7 empty read keeps data", 0, 0);
    check_flags("R7 after empty read");
    // keyboard disable masks irq_kbd only
    push(0, 8'h5a);
    mode_kbd_off = 1;
    #1 chk("R9 irq_kbd follows disable", {31'd0, irq_kbd}, 32'd0);
    check_flags("kbd off");
    mode_kbd_off = 0; mode_kbd_irq_en = 0;
    check_flags("kbd irq en off");
    mode_kbd_irq_en = 1;
    check_flags("kbd irq back");
    // R10 push and read same channel on the same edge
    host_read("R10 read old head", 1, 8'h77);
    check_flags("R10 after");
    host_read("R10 pushed byte queued", 0, 0);
    // R8 overfill keyboard
    for (int i = 0; i < 17; i++) push(0, 8'h80 + 8'(i));
    check_flags("R8 overfilled");
    push(1, 8'h44);
    check_flags("R8 full kbd with aux");
    for (int i = 0; i < 16; i++) host_read("R8 fifo contents", 0, 0);
    check_flags("R8 aux after kbd drain");
    host_read("R6 aux after drain", 0, 0);
    check_flags("end");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule